// File: doc/BRIEF.md
# Power Button Long-Press Handler

This block watches a debounced power-button level and a lid-open level, together with an indication from the power state controller that the platform is in one of its off states. A rising button level or a rising lid level while the platform is off produces a single-cycle power-on request for the controller.

Every button press also arms a hold timer that counts millisecond ticks. The timer is cancelled when the button is released. If the button stays held for the whole hold time, the block raises a forced-shutdown request. If the controller reports that the platform has finished dropping from run into suspend while the button is still down, the block raises the forced-shutdown request at once and drops the timer. The forced-shutdown request is a level. It stays set until the controller reports that it has completed the off-to-soft-off step.

Top module: `pwrkey_hold_top`

## Requirements
- R1: After reset both `powerOnReq` and `forceShutdown` are 0.
- R2: When `btnLevel` is sampled at 1 after being sampled at 0 and `anyOff` is 1 at that edge, `powerOnReq` is 1 for exactly the one cycle that follows that edge.
- R3: Keeping the button held does not repeat the power-on request. A press while `anyOff` is 0 gives no request.
- R4: A 0-to-1 change of `lidOpen` while `anyOff` is 1 gives a one-cycle `powerOnReq`. A lid opening while `anyOff` is 0 gives none.
- R5: Each press arms a hold timer. A `msTick` in the press cycle is not counted. `forceShutdown` rises in the cycle after the edge that samples the HOLD_MS-th `msTick` seen while the button is held.
- R6: Releasing the button before expiry cancels the timer, and no later tick raises `forceShutdown`. A new press restarts the full count.
- R7: `suspendDone` sampled at 1 while `btnLevel` is 1 sets `forceShutdown` in the next cycle and cancels the timer, so further held ticks do not raise it again.
- R8: `forceShutdown` stays 1 until `offAck` is sampled at 1. When a set and `offAck` fall in the same cycle, the set wins.
- R9: `suspendDone` while the button is released has no effect on `forceShutdown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse each millisecond |
| btnLevel | input | 1 | Debounced button level, 1 = pressed |
| lidOpen | input | 1 | Lid level, 1 = open |
| anyOff | input | 1 | Platform is in an off state |
| suspendDone | input | 1 | Pulse: run-to-suspend transition finished |
| offAck | input | 1 | Pulse: controller reached off-to-soft-off |
| powerOnReq | output | 1 | One-cycle power-on request |
| forceShutdown | output | 1 | Forced-shutdown request level |

## Verification
The hardest situations to reach are the collisions: the final counting tick landing in the same cycle as an acknowledge, and a suspend finishing while the timer is part-way through its count. The bench reaches them by stepping `msTick` by hand, one pulse at a time, after a press. This lets it stop exactly one tick short of expiry and then apply the colliding input on the cycle that matters. After a suspend-forced shutdown, the bench acknowledges with the button still held and then keeps ticking well past the hold time. This shows at the output that the timer was really dropped.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;
  typedef struct packed {
    logic armTmr;
    logic cancelTmr;
    logic setForce;
    logic clrForce;
    logic onPulse;
  } pwrkey_stb_t;
endpackage

// File: rtl/pwrkey_dp.sv
module pwrkey_dp
  import pwrkey_pkg::*;
#(
  parameter int HOLD_MS = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        msTick,
  input  pwrkey_stb_t stb,
  output logic        tmrExpire,
  output logic        tmrArmed,
  output logic        forceShutdown,
  output logic        powerOnReq
);
  localparam int CNT_W = $clog2(HOLD_MS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_MS - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             armedQ;
  logic             forceQ;
  logic             onQ;

  assign tmrExpire     = armedQ && msTick && (holdCnt == LAST_CNT);
  assign tmrArmed      = armedQ;
  assign forceShutdown = forceQ;
  assign powerOnReq    = onQ;

  // hold timer: cancel beats arm, arm restarts the count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ  <= 1'b0;
      holdCnt <= '0;
    end else if (stb.cancelTmr) begin
      armedQ  <= 1'b0;
      holdCnt <= '0;
    end else if (stb.armTmr) begin
      armedQ  <= 1'b1;
      holdCnt <= '0;
    end else if (armedQ && msTick) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // request registers: a new set outranks the acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceQ <= 1'b0;
      onQ    <= 1'b0;
    end else begin
      onQ <= stb.onPulse;
      if (stb.setForce)      forceQ <= 1'b1;
      else if (stb.clrForce) forceQ <= 1'b0;
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (holdCnt <= LAST_CNT));

  p_force_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (forceQ && !stb.clrForce) |=> forceQ);

  p_idle_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (holdCnt == '0));
endmodule

// File: rtl/pwrkey_ctrl.sv
module pwrkey_ctrl
  import pwrkey_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        btnLevel,
  input  logic        lidOpen,
  input  logic        anyOff,
  input  logic        suspendDone,
  input  logic        offAck,
  input  logic        tmrExpire,
  input  logic        tmrArmed,
  input  logic        forceShutdown,
  output pwrkey_stb_t stb
);
  logic btnQ;
  logic lidQ;
  logic pressEdge;
  logic lidEdge;
  logic suspendHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      btnQ <= 1'b0;
      lidQ <= 1'b0;
    end else begin
      btnQ <= btnLevel;
      lidQ <= lidOpen;
    end
  end

  assign pressEdge   = btnLevel && !btnQ;
  assign lidEdge     = lidOpen && !lidQ;
  assign suspendHeld = suspendDone && btnLevel;

  always_comb begin
    stb           = '0;
    stb.onPulse   = (pressEdge || lidEdge) && anyOff;
    stb.armTmr    = pressEdge;
    stb.setForce  = (tmrExpire && btnLevel) || suspendHeld;
    stb.cancelTmr = !btnLevel || suspendHeld || tmrExpire;
    stb.clrForce  = offAck;
  end

  p_release_cancels_r6: assert property (@(posedge clk) disable iff (!rstN)
    !btnLevel |=> !tmrArmed);

  p_suspend_forces_r7: assert property (@(posedge clk) disable iff (!rstN)
    suspendHeld |=> (forceShutdown && !tmrArmed));

  p_no_repeat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (btnQ && !lidEdge) |-> !stb.onPulse);
endmodule

// File: rtl/pwrkey_hold_top.sv
module pwrkey_hold_top
  import pwrkey_pkg::*;
#(
  parameter int HOLD_MS = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic btnLevel,
  input  logic lidOpen,
  input  logic anyOff,
  input  logic suspendDone,
  input  logic offAck,
  output logic powerOnReq,
  output logic forceShutdown
);
  pwrkey_stb_t stb;
  logic        tmrExpire;
  logic        tmrArmed;

  pwrkey_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .btnLevel(btnLevel), .lidOpen(lidOpen),
    .anyOff(anyOff), .suspendDone(suspendDone), .offAck(offAck),
    .tmrExpire(tmrExpire), .tmrArmed(tmrArmed),
    .forceShutdown(forceShutdown), .stb(stb)
  );

  pwrkey_dp #(.HOLD_MS(HOLD_MS)) dp_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .stb(stb),
    .tmrExpire(tmrExpire), .tmrArmed(tmrArmed),
    .forceShutdown(forceShutdown), .powerOnReq(powerOnReq)
  );
endmodule

// File: tb/pwrkey_hold_top_tb.sv
module pwrkey_hold_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, btnLevel = 1'b0, lidOpen = 1'b0, anyOff = 1'b0;
  logic suspendDone = 1'b0, offAck = 1'b0;
  logic powerOnReq, forceShutdown;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrkey_hold_top #(.HOLD_MS(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .btnLevel(btnLevel),
    .lidOpen(lidOpen), .anyOff(anyOff), .suspendDone(suspendDone),
    .offAck(offAck), .powerOnReq(powerOnReq), .forceShutdown(forceShutdown)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1; step(); msTick = 1'b0; step();
    end
  endtask

  task automatic t_reset();
    chk("R1 powerOnReq after reset", powerOnReq, 1'b0);
    chk("R1 forceShutdown after reset", forceShutdown, 1'b0);
  endtask

  task automatic t_press_off();
    anyOff = 1'b1; btnLevel = 1'b1; step();
    chk("R2 pulse on press while off", powerOnReq, 1'b1);
    step();
    chk("R2 pulse lasts one cycle", powerOnReq, 1'b0);
    step(); step();
    chk("R3 held button no repeat", powerOnReq, 1'b0);
    btnLevel = 1'b0; step(); step();
  endtask

  task automatic t_press_on();
    anyOff = 1'b0; btnLevel = 1'b1; step();
    chk("R3 no pulse while on", powerOnReq, 1'b0);
    btnLevel = 1'b0; step();
  endtask

  task automatic t_lid();
    anyOff = 1'b1; lidOpen = 1'b1; step();
    chk("R4 lid open while off", powerOnReq, 1'b1);
    step();
    chk("R4 lid pulse one cycle", powerOnReq, 1'b0);
    lidOpen = 1'b0; anyOff = 1'b0; step();
    lidOpen = 1'b1; step();
    chk("R4 lid open while on", powerOnReq, 1'b0);
    lidOpen = 1'b0; step();
  endtask

  task automatic t_hold_expire();
    btnLevel = 1'b1; msTick = 1'b1; step(); msTick = 1'b0; step();
    tick(HOLD - 1);
    chk("R5 no force before last tick", forceShutdown, 1'b0);
    tick(1);
    chk("R5 force after full hold", forceShutdown, 1'b1);
    btnLevel = 1'b0; step(); step();
    chk("R8 force held without ack", forceShutdown, 1'b1);
    offAck = 1'b1; step(); offAck = 1'b0;
    chk("R8 ack clears force", forceShutdown, 1'b0);
  endtask

  task automatic t_release_cancel();
    btnLevel = 1'b1; step();
    tick(HOLD - 1);
    btnLevel = 1'b0; step();
    tick(3);
    chk("R6 release cancels timer", forceShutdown, 1'b0);
    btnLevel = 1'b1; step();
    tick(HOLD - 1);
    chk("R6 re-press restarts count", forceShutdown, 1'b0);
    tick(1);
    chk("R6 re-press expires after full hold", forceShutdown, 1'b1);
    btnLevel = 1'b0; offAck = 1'b1; step(); offAck = 1'b0; step();
  endtask

  task automatic t_suspend();
    btnLevel = 1'b1; step();
    tick(2);
    suspendDone = 1'b1; step(); suspendDone = 1'b0;
    chk("R7 suspend with held button forces", forceShutdown, 1'b1);
    offAck = 1'b1; step(); offAck = 1'b0;
    chk("R7 ack after suspend force", forceShutdown, 1'b0);
    tick(HOLD + 2);
    chk("R7 timer cancelled by suspend", forceShutdown, 1'b0);
    btnLevel = 1'b0; step();
  endtask

  task automatic t_suspend_released();
    suspendDone = 1'b1; step(); suspendDone = 1'b0; step();
    chk("R9 suspend with released button", forceShutdown, 1'b0);
  endtask

  task automatic t_set_vs_ack();
    btnLevel = 1'b1; step();
    tick(HOLD - 1);
    msTick = 1'b1; offAck = 1'b1; step(); msTick = 1'b0; offAck = 1'b0;
    chk("R8 set wins over ack", forceShutdown, 1'b1);
    btnLevel = 1'b0; offAck = 1'b1; step(); offAck = 1'b0;
    chk("R8 later ack clears", forceShutdown, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    t_reset();
    t_press_off();
    t_press_on();
    t_lid();
    t_hold_expire();
    t_release_cancel();
    t_suspend();
    t_suspend_released();
    t_set_vs_ack();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule